// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block holds the four power-control status bits of a small processor core and turns them into run enables for the core, three gated clocks (main, subsystem, auxiliary) and two oscillators (a fast digitally controlled oscillator and a low-frequency crystal oscillator). Software enters a sleep mode by setting bits in the status register. An oscillator is stopped only when nothing running still draws on it. Each source-select input names the oscillator behind the main or subsystem clock.

A pending interrupt wakes the block in hardware. The current bits are saved, the sleep bits that stop the main clock are cleared, and a service flag is raised. A return strobe reloads the bits from the value presented with it, which may be the saved copy or an edited one, so the block resumes either the old mode or a new one. In the deepest mode, with all four bits set, only the non-maskable wake input gets through. Each clock gate captures its enable in a latch during the low phase of its source clock.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After reset the status bits, the saved bits and the service flag are all zero, and every enable output is 1.
- R2: Status bit 0 (CPU off) drives `cpu_en` and `mclk_en` low. On its own it leaves `smclk_en`, `aclk_en`, `dco_en` and `lfxt_en` high.
- R3: Status bit 3 (subsystem clock off) drives `smclk_en` low.
- R4: Status bit 2 (fast oscillator off) drives `dco_en` low unless select code 0 (fast oscillator) names the source of a clock whose enable is high. That clock can be the main clock through `mclk_sel` or the subsystem clock through `smclk_sel`.
- R5: Status bit 1 (crystal off) drives `lfxt_en` low unless select code 1 (crystal) names the source of an enabled main or subsystem clock. `aclk_en` always equals `lfxt_en`.
- R6: With all four status bits set (deepest mode) every enable is low. `irq_pending` has no effect there, and only `nmi_wake` wakes the block.
- R7: A wake fires when the service flag is clear and either `nmi_wake` is high, or `irq_pending` is high outside the deepest mode. One cycle later `saved_bits` holds the old status bits, bits 0, 1 and 3 are cleared, bit 2 is kept, and `in_service` is 1. Wake requests are ignored while `in_service` is 1.
- R8: `reti` while `in_service` is 1 loads `reti_bits` into the status bits one cycle later and clears `in_service`. `reti` outside service is ignored.
- R9: `sr_wr` loads `sr_wdata` into the status bits one cycle later, but only while bit 0 is clear and no wake or return acts in the same cycle.
- R10: Each gated clock output is its source clock ANDed with its enable as captured while the source is low. An enable change made at a source rising edge first affects the pulse at the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sr_wr | input | 1 | Software write strobe for the status bits |
| sr_wdata | input | 4 | Write value: bit0 CPU off, bit1 crystal off, bit2 fast osc off, bit3 subsystem clock off |
| irq_pending | input | 1 | Maskable interrupt request |
| nmi_wake | input | 1 | Non-maskable wake request |
| reti | input | 1 | Return-from-service strobe |
| reti_bits | input | 4 | Status bits restored on return |
| mclk_sel | input | 2 | Main clock source: 0 fast osc, 1 crystal, 2/3 other |
| smclk_sel | input | 2 | Subsystem clock source, same codes |
| mclk_src | input | 1 | Ungated main clock |
| smclk_src | input | 1 | Ungated subsystem clock |
| aclk_src | input | 1 | Ungated auxiliary clock |
| cpu_en | output | 1 | Core run enable |
| mclk_en | output | 1 | Main clock enable |
| smclk_en | output | 1 | Subsystem clock enable |
| aclk_en | output | 1 | Auxiliary clock enable |
| dco_en | output | 1 | Fast oscillator enable |
| lfxt_en | output | 1 | Crystal oscillator enable |
| mclk_g | output | 1 | Gated main clock |
| smclk_g | output | 1 | Gated subsystem clock |
| aclk_g | output | 1 | Gated auxiliary clock |
| sr_bits | output | 4 | Current status bits |
| saved_bits | output | 4 | Status bits saved at the last wake |
| in_service | output | 1 | Interrupt service in progress |

## Verification
The bench steps through mode entries with both select inputs set to the fast oscillator, then to the crystal, then split between them, so that an oscillator kept alive by a consumer can be told apart from one stopped by its bit. Wakes are tried from light and deep modes, with the maskable and non-maskable inputs. Returns use both the unmodified saved copy and edited values. The stray strobes (a write while the core is off, a return outside service, a request during service) show whether each one is ignored. Gated-clock pulse counts over fixed windows separate a running clock from a stopped one.

// File: rtl/lpm_pkg.sv
// Shared constants for the low-power clock controller.
// Assumes a 4-bit status field and 2-bit source selects.
package lpm_pkg;
    localparam int SR_W     = 4;
    localparam int SEL_W    = 2;
    localparam int NUM_GCLK = 3;

    localparam int B_CPUOFF = 0;
    localparam int B_XTOFF  = 1;
    localparam int B_FOFF   = 2;
    localparam int B_SUBOFF = 3;

    localparam logic [SEL_W-1:0] SRC_FAST = 2'd0;
    localparam logic [SEL_W-1:0] SRC_XTAL = 2'd1;

    localparam logic [SR_W-1:0] SR_DEEPEST  = 4'b1111;
    localparam logic [SR_W-1:0] WAKE_CLEAR  = 4'b1011;
endpackage

// File: rtl/lpm_status_reg.sv
// Status-bit register with wake, save and restore.
// Priority: wake > return > software write. Writes are dropped while the core is off.
module lpm_status_reg
    import lpm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sr_wr,
    input  logic [SR_W-1:0] sr_wdata,
    input  logic            irq_pending,
    input  logic            nmi_wake,
    input  logic            reti,
    input  logic [SR_W-1:0] reti_bits,
    output logic [SR_W-1:0] sr_q,
    output logic [SR_W-1:0] saved_q,
    output logic            svc_q
);
    logic wake_go;
    logic ret_go;
    logic wr_go;

    // Decide which of the three update sources acts this cycle.
    always_comb begin
        wake_go = !svc_q && (nmi_wake || (irq_pending && (sr_q != SR_DEEPEST)));
        ret_go  = !wake_go && reti && svc_q;
        wr_go   = !wake_go && !ret_go && sr_wr && !sr_q[B_CPUOFF];
    end

    // Update status, saved copy and service flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q    <= '0;
            saved_q <= '0;
            svc_q   <= 1'b0;
        end else if (wake_go) begin
            saved_q <= sr_q;
            sr_q    <= sr_q & ~WAKE_CLEAR;
            svc_q   <= 1'b1;
        end else if (ret_go) begin
            sr_q    <= reti_bits;
            svc_q   <= 1'b0;
        end else if (wr_go) begin
            sr_q    <= sr_wdata;
        end
    end
endmodule

// File: rtl/lpm_clk_policy.sv
// Maps status bits and source selects to clock and oscillator enables.
// An oscillator stays on while an enabled clock still draws from it.
module lpm_clk_policy
    import lpm_pkg::*;
(
    input  logic [SR_W-1:0]  sr,
    input  logic [SEL_W-1:0] mclk_sel,
    input  logic [SEL_W-1:0] smclk_sel,
    output logic             cpu_en,
    output logic             mclk_en,
    output logic             smclk_en,
    output logic             aclk_en,
    output logic             dco_en,
    output logic             lfxt_en
);
    logic fast_used;
    logic xtal_used;

    // Derive enables from the bits and oscillator demand.
    always_comb begin
        cpu_en    = !sr[B_CPUOFF];
        mclk_en   = !sr[B_CPUOFF];
        smclk_en  = !sr[B_SUBOFF];
        fast_used = (mclk_en && (mclk_sel == SRC_FAST)) ||
                    (smclk_en && (smclk_sel == SRC_FAST));
        xtal_used = (mclk_en && (mclk_sel == SRC_XTAL)) ||
                    (smclk_en && (smclk_sel == SRC_XTAL));
        dco_en    = !sr[B_FOFF] || fast_used;
        lfxt_en   = !sr[B_XTOFF] || xtal_used;
        aclk_en   = lfxt_en;
    end
endmodule

// File: rtl/lpm_clk_gate.sv
// Latch-based clock gate: enable is captured while the source is low,
// so the output never carries a shortened pulse.
module lpm_clk_gate (
    input  logic clk_src,
    input  logic en,
    output logic clk_gated
);
    logic en_lat;

    // Transparent while the source clock is low.
    always_latch begin
        if (!clk_src) en_lat = en;
    end

    assign clk_gated = clk_src & en_lat;
endmodule

// File: rtl/lpm_clk_ctrl.sv
// Top of the low-power clock controller: status register, enable policy
// and one latch gate per controlled clock.
module lpm_clk_ctrl
    import lpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sr_wr,
    input  logic [SR_W-1:0]  sr_wdata,
    input  logic             irq_pending,
    input  logic             nmi_wake,
    input  logic             reti,
    input  logic [SR_W-1:0]  reti_bits,
    input  logic [SEL_W-1:0] mclk_sel,
    input  logic [SEL_W-1:0] smclk_sel,
    input  logic             mclk_src,
    input  logic             smclk_src,
    input  logic             aclk_src,
    output logic             cpu_en,
    output logic             mclk_en,
    output logic             smclk_en,
    output logic             aclk_en,
    output logic             dco_en,
    output logic             lfxt_en,
    output logic             mclk_g,
    output logic             smclk_g,
    output logic             aclk_g,
    output logic [SR_W-1:0]  sr_bits,
    output logic [SR_W-1:0]  saved_bits,
    output logic             in_service
);
    logic [NUM_GCLK-1:0] g_src;
    logic [NUM_GCLK-1:0] g_en;
    logic [NUM_GCLK-1:0] g_out;

    lpm_status_reg u_sr (
        .clk(clk), .rst_n(rst_n), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
        .irq_pending(irq_pending), .nmi_wake(nmi_wake), .reti(reti),
        .reti_bits(reti_bits), .sr_q(sr_bits), .saved_q(saved_bits),
        .svc_q(in_service)
    );

    lpm_clk_policy u_pol (
        .sr(sr_bits), .mclk_sel(mclk_sel), .smclk_sel(smclk_sel),
        .cpu_en(cpu_en), .mclk_en(mclk_en), .smclk_en(smclk_en),
        .aclk_en(aclk_en), .dco_en(dco_en), .lfxt_en(lfxt_en)
    );

    assign g_src = {aclk_src, smclk_src, mclk_src};
    assign g_en  = {aclk_en, smclk_en, mclk_en};

    for (genvar i = 0; i < NUM_GCLK; i++) begin : g_gate
        lpm_clk_gate u_gate (.clk_src(g_src[i]), .en(g_en[i]), .clk_gated(g_out[i]));
    end

    assign mclk_g  = g_out[0];
    assign smclk_g = g_out[1];
    assign aclk_g  = g_out[2];
endmodule

// File: rtl/lpm_clk_ctrl_sva.sv
// Checker for the low-power clock controller, attached by bind.
module lpm_clk_ctrl_sva
    import lpm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sr_wr,
    input logic             irq_pending,
    input logic             nmi_wake,
    input logic             reti,
    input logic [SR_W-1:0]  reti_bits,
    input logic [SEL_W-1:0] mclk_sel,
    input logic [SEL_W-1:0] smclk_sel,
    input logic             cpu_en,
    input logic             mclk_en,
    input logic             smclk_en,
    input logic             aclk_en,
    input logic             dco_en,
    input logic             lfxt_en,
    input logic [SR_W-1:0]  sr_bits,
    input logic [SR_W-1:0]  saved_bits,
    input logic             in_service
);
    AST_DEEP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_bits == SR_DEEPEST) |-> !(mclk_en || smclk_en || aclk_en || dco_en || lfxt_en)); // R6

    AST_DEEP_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((sr_bits == SR_DEEPEST) && !in_service && !nmi_wake) |=> (sr_bits == SR_DEEPEST)); // R6

    AST_FAST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((mclk_en && mclk_sel == SRC_FAST) || (smclk_en && smclk_sel == SRC_FAST)) |-> dco_en); // R4

    AST_XTAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((mclk_en && mclk_sel == SRC_XTAL) || (smclk_en && smclk_sel == SRC_XTAL)) |-> lfxt_en); // R5

    AST_WAKE_RUNS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_service && nmi_wake) |=> (cpu_en && in_service)); // R7

    AST_WAKE_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_service && nmi_wake) |=> (saved_bits == $past(sr_bits))); // R7

    AST_RETURN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && reti) |=> (sr_bits == $past(reti_bits) && !in_service)); // R8

    AST_WRITE_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_en && !in_service && !nmi_wake && !irq_pending) |=> $stable(sr_bits)); // R9
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_sva u_sva (.*);

// File: tb/lpm_clk_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with the outputs on every falling edge.
module lpm_clk_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sr_wr = 1'b0;
    logic [3:0] sr_wdata = '0;
    logic       irq_pending = 1'b0;
    logic       nmi_wake = 1'b0;
    logic       reti = 1'b0;
    logic [3:0] reti_bits = '0;
    logic [1:0] mclk_sel = 2'd0;
    logic [1:0] smclk_sel = 2'd0;
    logic cpu_en, mclk_en, smclk_en, aclk_en, dco_en, lfxt_en;
    logic mclk_g, smclk_g, aclk_g, in_service;
    logic [3:0] sr_bits, saved_bits;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";
    bit compare_on = 1'b0;

    always #2.5 clk = ~clk;

    lpm_clk_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
        .irq_pending(irq_pending), .nmi_wake(nmi_wake), .reti(reti),
        .reti_bits(reti_bits), .mclk_sel(mclk_sel), .smclk_sel(smclk_sel),
        .mclk_src(clk), .smclk_src(clk), .aclk_src(clk),
        .cpu_en(cpu_en), .mclk_en(mclk_en), .smclk_en(smclk_en),
        .aclk_en(aclk_en), .dco_en(dco_en), .lfxt_en(lfxt_en),
        .mclk_g(mclk_g), .smclk_g(smclk_g), .aclk_g(aclk_g),
        .sr_bits(sr_bits), .saved_bits(saved_bits), .in_service(in_service)
    );

    // Reference state
    int m_sr = 0, m_saved = 0, m_svc = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sr <= 0; m_saved <= 0; m_svc <= 0;
        end else if (m_svc == 0 && (nmi_wake || (irq_pending && m_sr != 15))) begin
            m_saved <= m_sr;
            m_sr    <= m_sr % 8 >= 4 ? 4 : 0;
            m_svc   <= 1;
        end else if (reti && m_svc == 1) begin
            m_sr  <= reti_bits;
            m_svc <= 0;
        end else if (sr_wr && (m_sr % 2 == 0)) begin
            m_sr <= sr_wdata;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    // Compare every falling edge
    always @(negedge clk) begin
        if (compare_on) begin
            int main_on, sub_on, fast, xtal;
            main_on = (m_sr % 2 == 0);
            sub_on  = (m_sr < 8);
            fast = ((m_sr / 4) % 2 == 0) || (main_on && mclk_sel == 0) || (sub_on && smclk_sel == 0);
            xtal = ((m_sr / 2) % 2 == 0) || (main_on && mclk_sel == 1) || (sub_on && smclk_sel == 1);
            chk("cpu_en",   cpu_en,   main_on);
            chk("mclk_en",  mclk_en,  main_on);
            chk("smclk_en", smclk_en, sub_on);
            chk("dco_en",   dco_en,   fast);
            chk("lfxt_en",  lfxt_en,  xtal);
            chk("aclk_en",  aclk_en,  xtal);
            chk("sr_bits",  sr_bits,  m_sr);
            chk("saved",    saved_bits, m_saved);
            chk("in_service", in_service, m_svc);
        end
    end

    int mclk_cnt = 0;
    always @(posedge mclk_g) mclk_cnt++;

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_wr(input logic [3:0] v);
        sr_wr = 1'b1; sr_wdata = v; step(1); sr_wr = 1'b0; step(1);
    endtask

    task automatic pulse_irq(input bit nmi);
        if (nmi) nmi_wake = 1'b1; else irq_pending = 1'b1;
        step(1); nmi_wake = 1'b0; irq_pending = 1'b0; step(1);
    endtask

    task automatic pulse_ret(input logic [3:0] v);
        reti = 1'b1; reti_bits = v; step(1); reti = 1'b0; step(1);
    endtask

    // Watchdog
    initial begin
        #(5.0 * 20000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        compare_on = 1'b1;
        cur_req = "R1"; step(2);
        cur_req = "R2"; pulse_wr(4'b0001); step(2);            // LPM0
        cur_req = "R9"; pulse_wr(4'b0000); step(1);            // ignored: core off
        cur_req = "R7"; pulse_irq(1'b0); step(1);              // wake
        cur_req = "R7"; pulse_irq(1'b0); step(1);              // ignored in service
        cur_req = "R8"; pulse_ret(4'b1101); step(2);           // edited return -> LPM3
        cur_req = "R4"; pulse_irq(1'b0); step(1);              // fast kept for main clock
        cur_req = "R4"; smclk_sel = 2'd0; pulse_ret(4'b0101); step(2); // LPM1, fast feeds subsystem
        cur_req = "R4"; smclk_sel = 2'd1; step(2);             // fast released, crystal used
        cur_req = "R8"; pulse_ret(4'b0000); step(1);           // return outside service ignored
        cur_req = "R3"; pulse_irq(1'b0); pulse_wr(4'b1000); step(2);
        cur_req = "R5"; mclk_sel = 2'd1; pulse_wr(4'b1010); step(2);
        cur_req = "R5"; mclk_sel = 2'd0; step(2);
        cur_req = "R6"; pulse_ret(4'b1111); step(2);
        cur_req = "R6"; pulse_irq(1'b0); step(2);              // maskable ignored
        cur_req = "R6"; pulse_irq(1'b1); step(2);              // non-maskable wakes
        cur_req = "R8"; pulse_ret(4'b0000); step(2);

        cur_req = "R10";
        mclk_cnt = 0; step(4);
        chk("mclk_g pulses active", mclk_cnt, 4);
        pulse_wr(4'b0001); step(1);
        mclk_cnt = 0; step(4);
        chk("mclk_g pulses asleep", mclk_cnt, 0);
        pulse_irq(1'b0);
        mclk_cnt = 0; step(4);
        chk("mclk_g pulses woken", mclk_cnt, 4);

        compare_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule